// File: doc/BRIEF.md
# I2C Master Start/Stop Sequencer

This block is the master-side control of an I2C controller. A start request made while the device does not own the bus waits until the bus is free. It then pulls SDA low with SCL released, holds that for one programmed SCL phase, and pulls SCL low. From then on the device is master. Software then writes the address byte, and the sequencer hands the lines to an external byte shifter through a one-cycle go pulse.

A start request made while the device is already master is held until the next data-register write. That write launches a repeated start, and the written byte then goes out as address plus direction. A stop request makes the sequencer lift SCL while holding SDA low for one phase, then release SDA. An optional stall after the address byte blocks further data writes until software clears the stall flag. A one-shot acknowledge register sets the level driven in the next acknowledge slot while receiving. Six sticky status flags are combined into one interrupt line. Pulling the module enable low clears all control and status state.

The byte shifter and the slave logic are outside this block. They report to it through event strobes.

Top module: `i2c_master_seq`

## Requirements
- R1: While not master, a pending start request drives nothing while `bus_busy` is high. The first rising edge of the clock with `bus_busy` low and the request pending begins the start condition: `sda_low`=1 and `scl_low`=0.
- R2: The start hold lasts exactly max(`scl_div`,1) clock cycles. After it, `sda_low`=1, `scl_low`=1, `master`=1 and `start_pend`=0.
- R3: A start request made while master changes no line until a `data_wr` arrives. The write then gives these phases, each of max(`scl_div`,1) cycles, in order: SDA released with SCL low, then both released, then SDA low with SCL released. After the last phase `tx_go` pulses for one cycle with both lines released.
- R4: `stop_req` while not master is ignored (`stop_pend` stays 0). While master and waiting between bytes, a pending stop gives SDA low with SCL released for max(`scl_div`,1) cycles, then both lines released, with `master`=0 and `stop_pend`=0.
- R5: `bus_err` clears `start_pend`, `stop_pend` and `master` on the next edge, releases both lines, and sets status bit 0.
- R6: With `stall_en`=1, the completion of the first byte after a start sets status bit 3. While that bit is set, `data_wr` is ignored: no `tx_go`, and SCL stays low. Status bit 3 reads 0 on any cycle after a cycle with `stall_en`=0.
- R7: `ack_wr` loads the acknowledge bit from `ack_wdata`. `ack_nack` equals that bit while `rx_mode`=1 and is 0 while `rx_mode`=0. `ack_tick` clears the bit only while `rx_mode`=1.
- R8: `irq` = `int_en` AND (sts[0] OR sts[1] OR sts[2] OR sts[3] OR sts[4] OR (sts[5] AND `match_int_en`)).
- R9: After reset, and on the cycle after `en`=0: all outputs read 0, and the acknowledge bit is cleared.
- R10: Status bits are bus error [0], NACK after a sent byte [1], byte done [2], stall [3], slave-receive stop [4] and new match [5]. Each is sticky and is cleared by a 1 in the same position of `sts_clr`. A set event in the same cycle wins over the clear.
- R11: `data_wr` while master between bytes, with no start pending and no stall, produces a one-cycle `tx_go` and releases both lines until `byte_done`. At `byte_done` the sequencer returns to holding both lines low and sets status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Module enable; low clears all state |
| scl_div | input | DIV_W | Length of one SCL phase in clocks (0 acts as 1) |
| start_req | input | 1 | Start request strobe |
| stop_req | input | 1 | Stop request strobe |
| ack_wr | input | 1 | Load strobe for the acknowledge bit |
| ack_wdata | input | 1 | Acknowledge bit value (1 = NACK) |
| stall_en | input | 1 | Stall after the address byte |
| int_en | input | 1 | Global interrupt enable |
| match_int_en | input | 1 | Enable for the new-match interrupt source |
| data_wr | input | 1 | Data-register write strobe |
| bus_busy | input | 1 | Bus is owned by some master |
| bus_err | input | 1 | Bus error strobe |
| byte_done | input | 1 | Shifter finished a byte including its acknowledge |
| tx_nack | input | 1 | NACK received after a sent byte |
| ack_tick | input | 1 | End of an acknowledge cycle |
| rx_mode | input | 1 | Device is receiving |
| slv_stop | input | 1 | Stop seen in slave receive mode |
| new_match | input | 1 | New slave address match |
| sts_clr | input | 6 | Write-one-to-clear mask for status bits |
| sda_low | output | 1 | Drive SDA low |
| scl_low | output | 1 | Drive SCL low |
| master | output | 1 | Device owns the bus |
| start_pend | output | 1 | Start request pending |
| stop_pend | output | 1 | Stop request pending |
| tx_go | output | 1 | One-cycle pulse: shifter sends the written byte |
| ack_nack | output | 1 | Level for the next acknowledge slot (1 = NACK) |
| sts | output | 6 | Sticky status flags |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle the relations that hold at any moment. A start condition never begins while the bus was busy. Mastership is gained only right after a start hold and lost only through a stop or an error, and the stop ends with SDA rising while SCL is high. A bus error or a disable leaves no request or status behind. Stop requests are ignored when not master, the stall flag is forced clear, and `tx_go` lasts one cycle. Only the bench's scenarios can show the counted phase lengths for each SCL setting, the exact order of the repeated-start phases, and the deferral of a repeated start until the data write. The same holds for the blocking of writes under stall, the one-shot acknowledge bit across transmit and receive, and the interrupt combination under random enables and clears.

// File: rtl/i2c_master_seq.sv
module i2c_master_seq #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] scl_div,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             ack_wr,
  input  logic             ack_wdata,
  input  logic             stall_en,
  input  logic             int_en,
  input  logic             match_int_en,
  input  logic             data_wr,
  input  logic             bus_busy,
  input  logic             bus_err,
  input  logic             byte_done,
  input  logic             tx_nack,
  input  logic             ack_tick,
  input  logic             rx_mode,
  input  logic             slv_stop,
  input  logic             new_match,
  input  logic [5:0]       sts_clr,
  output logic             sda_low,
  output logic             scl_low,
  output logic             master,
  output logic             start_pend,
  output logic             stop_pend,
  output logic             tx_go,
  output logic             ack_nack,
  output logic [5:0]       sts,
  output logic             irq
);

  typedef enum logic [2:0] {IDLE, START, OWN, XFER, RS_LO, RS_HI, SP_HI} st_t;

  st_t st, st_n;
  logic [DIV_W-1:0] cnt;
  logic             rs, addr_b, ack_bit;
  logic [5:0]       sts_set;

  wire [DIV_W-1:0] div_last = (scl_div == '0) ? '0 : scl_div - 1'b1;
  wire timed = st inside {START, RS_LO, RS_HI, SP_HI};
  wire tdone = timed && (cnt == div_last);
  wire start_end = (st == START) && tdone;
  wire stop_end  = (st == SP_HI) && tdone;
  wire byte_end  = (st == XFER) && byte_done;
  wire wr_ok     = data_wr && !sts[3];

  always_comb begin
    st_n = st;
    case (st)
      IDLE:  if (start_pend && !bus_busy) st_n = START;
      START: if (tdone) st_n = rs ? XFER : OWN;
      OWN:   if (stop_pend) st_n = SP_HI;
             else if (wr_ok && start_pend) st_n = RS_LO;
             else if (wr_ok) st_n = XFER;
      XFER:  if (byte_done) st_n = OWN;
      RS_LO: if (tdone) st_n = RS_HI;
      RS_HI: if (tdone) st_n = START;
      SP_HI: if (tdone) st_n = IDLE;
      default: st_n = IDLE;
    endcase
  end

  assign sts_set = {new_match, slv_stop, byte_end && addr_b && stall_en,
                    byte_end, tx_nack, bus_err};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; rs <= 1'b0; addr_b <= 1'b0; ack_bit <= 1'b0;
      master <= 1'b0; start_pend <= 1'b0; stop_pend <= 1'b0; tx_go <= 1'b0;
      sts <= '0;
    end else if (!en) begin
      st <= IDLE; cnt <= '0; rs <= 1'b0; addr_b <= 1'b0; ack_bit <= 1'b0;
      master <= 1'b0; start_pend <= 1'b0; stop_pend <= 1'b0; tx_go <= 1'b0;
      sts <= '0;
    end else begin
      st    <= bus_err ? IDLE : st_n;
      cnt   <= (timed && !tdone && !bus_err) ? cnt + 1'b1 : '0;
      tx_go <= !bus_err && (st != XFER) && (st_n == XFER);

      if (bus_err) master <= 1'b0;
      else if (start_end) master <= 1'b1;
      else if (stop_end) master <= 1'b0;

      if (bus_err) start_pend <= 1'b0;
      else if (start_req) start_pend <= 1'b1;
      else if (start_end) start_pend <= 1'b0;

      if (bus_err) stop_pend <= 1'b0;
      else if (stop_req && master) stop_pend <= 1'b1;
      else if (stop_end) stop_pend <= 1'b0;

      if (bus_err || start_end) rs <= 1'b0;
      else if (st == OWN && st_n == RS_LO) rs <= 1'b1;

      if (bus_err || byte_end) addr_b <= 1'b0;
      else if (start_end) addr_b <= 1'b1;

      if (ack_wr) ack_bit <= ack_wdata;
      else if (ack_tick && rx_mode) ack_bit <= 1'b0;

      sts <= (sts & ~sts_clr) | sts_set;
      if (!stall_en) sts[3] <= 1'b0;
    end
  end

  assign sda_low  = st inside {START, OWN, SP_HI};
  assign scl_low  = st inside {OWN, RS_LO};
  assign ack_nack = rx_mode & ack_bit;
  assign irq      = int_en & (|sts[4:0] | (sts[5] & match_int_en));

endmodule

module i2c_master_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       bus_busy,
  input logic       bus_err,
  input logic       stall_en,
  input logic       stop_req,
  input logic       sda_low,
  input logic       scl_low,
  input logic       master,
  input logic       start_pend,
  input logic       stop_pend,
  input logic       tx_go,
  input logic [5:0] sts,
  input logic       irq
);

  a_r1_start_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!master && sda_low && !$past(sda_low) && $past(en) && !$past(bus_err)) |-> !$past(bus_busy));

  a_r2_master_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master) |-> ($past(sda_low) && !$past(scl_low)));

  a_r4_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(master) && $past(en) && !$past(bus_err)) |->
      (!sda_low && !scl_low && $past(sda_low) && !$past(scl_low)));

  a_r4_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_req) && !$past(master) && !$past(stop_pend)) |-> !stop_pend);

  a_r5_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_err) && $past(en)) |-> (!master && !start_pend && !stop_pend && sts[0]));

  a_r6_stall_forced: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!stall_en) |-> !sts[3]);

  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (!master && !start_pend && !stop_pend && !tx_go && sts == 6'd0 && !irq));

  a_r11_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

endmodule

bind i2c_master_seq i2c_master_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bus_busy(bus_busy), .bus_err(bus_err),
  .stall_en(stall_en), .stop_req(stop_req), .sda_low(sda_low), .scl_low(scl_low),
  .master(master), .start_pend(start_pend), .stop_pend(stop_pend), .tx_go(tx_go),
  .sts(sts), .irq(irq)
);

// File: tb/tb_i2c_master_seq.sv
module tb_i2c_master_seq;

  logic clk = 0, rst_n = 0, en = 1;
  logic [7:0] scl_div = 8'd1;
  logic start_req = 0, stop_req = 0, ack_wr = 0, ack_wdata = 0, stall_en = 0;
  logic int_en = 0, match_int_en = 0, data_wr = 0, bus_busy = 0, bus_err = 0;
  logic byte_done = 0, tx_nack = 0, ack_tick = 0, rx_mode = 0, slv_stop = 0, new_match = 0;
  logic [5:0] sts_clr = 0;
  logic sda_low, scl_low, master, start_pend, stop_pend, tx_go, ack_nack, irq;
  logic [5:0] sts;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_master_seq #(.DIV_W(8)) dut (.*);

  task automatic tk();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq(input logic [5:0] m, input logic ie, input logic mie);
    return ie & (m[0] | m[1] | m[2] | m[3] | m[4] | (m[5] & mie));
  endfunction

  function automatic int deff(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  task automatic phase(input logic s, input logic c, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(sda_low == s && scl_low == c && !tx_go, tag, {30'd0, sda_low, scl_low}, {30'd0, s, c});
      tk();
    end
  endtask

  task automatic clear_sts();
    sts_clr = 6'h3f; tk(); sts_clr = 0;
  endtask

  task automatic do_start(input int busy_cycles);
    bus_busy = (busy_cycles > 0);
    start_req = 1; tk(); start_req = 0;
    chk(start_pend == 1, "R1 pending", start_pend, 1);
    for (int i = 0; i < busy_cycles; i++) begin
      chk(sda_low == 0, "R1 waits busy", sda_low, 0);
      tk();
    end
    bus_busy = 0; tk();
    phase(1, 0, deff(scl_div), "R2 start hold");
    chk(sda_low && scl_low && master && !start_pend, "R2 owned",
        {sda_low, scl_low, master, start_pend}, 4'b1110);
  endtask

  task automatic do_stop();
    stop_req = 1; tk(); stop_req = 0;
    chk(stop_pend == 1, "R4 stop pending", stop_pend, 1);
    tk();
    phase(1, 0, deff(scl_div), "R4 stop phase");
    chk(!sda_low && !scl_low && !master && !stop_pend, "R4 released",
        {sda_low, scl_low, master, stop_pend}, 0);
  endtask

  task automatic send_byte(input string tag);
    data_wr = 1; tk(); data_wr = 0;
    chk(tx_go && !sda_low && !scl_low, tag, {tx_go, sda_low, scl_low}, 3'b100);
    tk();
    chk(!tx_go, "R11 go single", tx_go, 0);
  endtask

  initial begin
    logic [5:0] m;
    bit se, ie, mie;
    void'($urandom(32'h5eed));
    repeat (3) tk();
    rst_n = 1; tk();
    chk(!sda_low && !scl_low && !master && !start_pend && !stop_pend && !tx_go && sts == 0 && !irq,
        "R9 reset state", {sda_low, scl_low, master, tx_go, sts}, 0);

    stop_req = 1; tk(); stop_req = 0; tk();
    chk(stop_pend == 0, "R4 stop ignored idle", stop_pend, 0);

    scl_div = 0;
    do_start(0);
    do_stop();

    for (int it = 0; it < 24; it++) begin
      scl_div = 8'($urandom_range(0, 5));
      se = 1'($urandom_range(0, 1));
      ie = 1'($urandom_range(0, 1));
      stall_en = se; int_en = ie;
      clear_sts();
      do_start($urandom_range(0, 4));
      send_byte("R11 address go");
      byte_done = 1; tk(); byte_done = 0;
      m = {2'b00, se, 1'b1, 2'b00};
      chk(sts == m, "R6 R11 status after address", sts, m);
      chk(irq == exp_irq(m, ie, 0), "R8 irq after byte", irq, exp_irq(m, ie, 0));
      chk(scl_low && sda_low, "R11 hold after byte", {sda_low, scl_low}, 3);
      if (se) begin
        data_wr = 1; tk(); data_wr = 0; tk();
        chk(!tx_go && scl_low, "R6 write ignored when stalled", {tx_go, scl_low}, 1);
        clear_sts();
        chk(sts == 0, "R10 clear all", sts, 0);
      end
      if ($urandom_range(0, 1)) begin
        start_req = 1; tk(); start_req = 0;
        tk(); tk();
        chk(master && sda_low && scl_low && start_pend, "R3 deferred",
            {master, sda_low, scl_low, start_pend}, 4'b1111);
        clear_sts();
        data_wr = 1; tk(); data_wr = 0;
        phase(0, 1, deff(scl_div), "R3 rs low");
        phase(0, 0, deff(scl_div), "R3 rs high");
        phase(1, 0, deff(scl_div), "R3 rs hold");
        chk(tx_go && !sda_low && !scl_low && !start_pend, "R3 address go",
            {tx_go, sda_low, scl_low, start_pend}, 4'b1000);
        tk();
        byte_done = 1; tk(); byte_done = 0;
        chk(sts[3] == se, "R6 stall after repeated start", sts[3], se);
      end
      do_stop();
    end

    stall_en = 1; scl_div = 3;
    start_req = 1; tk(); start_req = 0; tk();
    chk(sda_low && !scl_low, "R1 start begins", {sda_low, scl_low}, 2);
    bus_err = 1; tk(); bus_err = 0;
    chk(!master && !start_pend && !sda_low && !scl_low && sts[0], "R5 error abort",
        {master, start_pend, sda_low, scl_low, sts[0]}, 1);
    stall_en = 0; tk();
    chk(sts[3] == 0, "R6 forced clear", sts[3], 0);

    m = sts;
    for (int it = 0; it < 40; it++) begin
      logic [5:0] clr, set;
      clr = 6'($urandom_range(0, 63));
      set = 0;
      set[0] = ($urandom_range(0, 5) == 0);
      set[1] = ($urandom_range(0, 3) == 0);
      set[4] = ($urandom_range(0, 3) == 0);
      set[5] = ($urandom_range(0, 3) == 0);
      ie = 1'($urandom_range(0, 1)); mie = 1'($urandom_range(0, 1));
      int_en = ie; match_int_en = mie; sts_clr = clr;
      bus_err = set[0]; tx_nack = set[1]; slv_stop = set[4]; new_match = set[5];
      tk();
      bus_err = 0; tx_nack = 0; slv_stop = 0; new_match = 0; sts_clr = 0;
      m = (m & ~clr) | set;
      chk(sts == m, "R10 sticky flags", sts, m);
      chk(irq == exp_irq(m, ie, mie), "R8 irq combine", irq, exp_irq(m, ie, mie));
    end

    clear_sts();
    rx_mode = 0; ack_wr = 1; ack_wdata = 1; tk(); ack_wr = 0;
    chk(ack_nack == 0, "R7 ignored while transmitting", ack_nack, 0);
    ack_tick = 1; tk(); ack_tick = 0;
    rx_mode = 1; #1;
    chk(ack_nack == 1, "R7 kept through tx ack", ack_nack, 1);
    ack_tick = 1; tk(); ack_tick = 0;
    chk(ack_nack == 0, "R7 one-shot clear", ack_nack, 0);

    scl_div = 2; int_en = 1;
    do_start(1);
    ack_wr = 1; ack_wdata = 1; tx_nack = 1; stop_req = 1; tk();
    ack_wr = 0; tx_nack = 0; stop_req = 0;
    chk(ack_nack && irq && stop_pend, "R7 R8 before disable", {ack_nack, irq, stop_pend}, 7);
    en = 0; tk(); en = 1;
    chk(!master && !stop_pend && !sda_low && !scl_low && sts == 0 && !irq && !ack_nack,
        "R9 disable clears", {master, stop_pend, sda_low, scl_low, irq, ack_nack}, 0);
    rx_mode = 0; tk();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule